// File: doc/BRIEF.md
# Branch Target Buffer

This block sits beside the fetch stage and answers, for the address being fetched, the question "where does fetch go next?" before the instruction has been decoded. It holds a small set of entries. Each entry pairs the word address of a branch that was recently taken with the word address that branch jumped to. Every entry is searched in parallel. A match sends fetch to the stored target. No match means the instruction is treated as not a branch, or as a branch not expected to be taken, and fetch moves on by one 4-byte word.

Branch resolution writes results back through an update port. A taken branch is added to the table, or its target is refreshed if it is already there. A branch that resolves not-taken loses its entry. New branches fill free entries first. When none are free, a rotating pointer picks the entry to overwrite. Lookup is purely combinational from the fetch address and the registered table. Updates land at the next clock edge.

Top module: `brtgt_buffer`

## Requirements
- R1: After reset every entry is invalid, so every lookup returns `lk_hit`=0.
- R2: On a miss, `lk_next_pc` equals `lk_pc`+4, wrapping modulo 2^32 (0xFFFFFFFC gives 0x00000000).
- R3: After a taken update (`up_valid`=1, `up_taken`=1) of an absent PC, a lookup of that PC from the next cycle on gives `lk_hit`=1 and `lk_next_pc` equal to the update target.
- R4: Matching compares only PC bits [31:2]; lookup bits [1:0] are ignored. Stored targets keep bits [31:2], and bits [1:0] of `lk_next_pc` on a hit are 0.
- R5: A taken update of a PC already present overwrites that entry's target and occupies no second entry.
- R6: A not-taken update of a present PC invalidates its entry. A not-taken update of an absent PC changes nothing.
- R7: While any entry is invalid, a taken update of an absent PC goes into an invalid entry, and no valid entry is displaced.
- R8: When all DEPTH entries are valid, a taken update of an absent PC replaces the entry at a rotating pointer. The pointer is 0 after reset and advances by one after each such replacement, wrapping after DEPTH-1. With an empty table filled in order, the first replacement evicts the oldest branch and the second evicts the next oldest.
- R9: With `up_valid`=0, the table does not change, whatever values the other update inputs carry.
- R10: A lookup in the same cycle as an update sees the table as it stood before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_pc | input | 32 | Fetch address to look up |
| lk_hit | output | 1 | A valid entry matches `lk_pc` |
| lk_next_pc | output | 32 | Predicted next fetch address |
| up_valid | input | 1 | A branch resolution is presented this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_target | input | 32 | Resolved target of the branch |
| up_taken | input | 1 | 1 if the branch was taken, 0 if it fell through |

## Verification
Lookup and update share a cycle whenever fetch presents an address while resolution is writing, and the sharpest case is the same address on both ports. The bench drives matching addresses on both ports in one vector for an allocation, a retarget and an invalidation. It then expects the lookup in that cycle to return the old result (a miss, the old target, or a still-valid hit) and the lookup in the following cycle to show the new one. Refills at a full table are judged the same way, by observing which earlier branch stops hitting.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;

    // What one update cycle does to the table.
    typedef enum logic [2:0] {
        UPD_IDLE,
        UPD_RETARGET,
        UPD_FILL,
        UPD_EVICT,
        UPD_DROP
    } upd_kind_e;

endpackage

// File: rtl/brtgt_cam.sv
module brtgt_cam #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 30,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]            key,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);

    logic [DEPTH-1:0] match;

    // One comparator per entry, all in parallel.
    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = valid[g] && (tags[g] == key);
    end

    assign hit = |match;

    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    // R5: update logic must never leave two entries holding one tag
    p_single_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

endmodule

// File: rtl/brtgt_victim.sv
module brtgt_victim #(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] valid,
    input  logic [IDX_W-1:0] rr_ptr,
    output logic             free_any,
    output logic [IDX_W-1:0] slot
);

    logic [IDX_W-1:0] free_idx;

    assign free_any = ~&valid;

    // Lowest-numbered invalid entry.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_idx = IDX_W'(i);
            end
        end
    end

    assign slot = free_any ? free_idx : rr_ptr;

endmodule

// File: rtl/brtgt_buffer.sv
module brtgt_buffer #(
    parameter int PC_W  = 32,
    parameter int ALIGN = 2,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic [PC_W-1:0] up_target,
    input  logic            up_taken
);
    import brtgt_pkg::*;

    localparam int TAG_W = PC_W - ALIGN;
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    typedef struct packed {
        logic [DEPTH-1:0]            valid;
        logic [DEPTH-1:0][TAG_W-1:0] tag;
        logic [DEPTH-1:0][TAG_W-1:0] tgt;
        logic [IDX_W-1:0]            rr;
    } state_t;

    state_t st_d, st_q;
    upd_kind_e kind_d;

    logic             lk_found;
    logic [IDX_W-1:0] lk_idx;
    logic             up_found;
    logic [IDX_W-1:0] up_idx;
    logic             free_any;
    logic [IDX_W-1:0] new_slot;
    logic [TAG_W-1:0] lk_key, up_key, up_tgt_word;
    logic             unused_low_bits;

    assign lk_key          = lk_pc[PC_W-1:ALIGN];
    assign up_key          = up_pc[PC_W-1:ALIGN];
    assign up_tgt_word     = up_target[PC_W-1:ALIGN];
    assign unused_low_bits = ^{up_pc[ALIGN-1:0], up_target[ALIGN-1:0]};

    brtgt_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_lk_cam (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (st_q.valid),
        .tags  (st_q.tag),
        .key   (lk_key),
        .hit   (lk_found),
        .idx   (lk_idx)
    );

    brtgt_cam #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_up_cam (
        .clk   (clk),
        .rst_n (rst_n),
        .valid (st_q.valid),
        .tags  (st_q.tag),
        .key   (up_key),
        .hit   (up_found),
        .idx   (up_idx)
    );

    brtgt_victim #(.DEPTH(DEPTH)) u_victim (
        .valid    (st_q.valid),
        .rr_ptr   (st_q.rr),
        .free_any (free_any),
        .slot     (new_slot)
    );

    // Lookup path: purely combinational from the registered table.
    assign lk_hit     = lk_found;
    assign lk_next_pc = lk_found ? {st_q.tgt[lk_idx], {ALIGN{1'b0}}}
                                 : lk_pc + PC_W'(4);

    // Classify the update.
    always_comb begin
        kind_d = UPD_IDLE;
        if (up_valid) begin
            if (up_taken) begin
                if (up_found)      kind_d = UPD_RETARGET;
                else if (free_any) kind_d = UPD_FILL;
                else               kind_d = UPD_EVICT;
            end else if (up_found) begin
                kind_d = UPD_DROP;
            end
        end
    end

    // Next-state computation.
    always_comb begin
        st_d = st_q;
        unique case (kind_d)
            UPD_RETARGET: begin
                st_d.tgt[up_idx] = up_tgt_word;
            end
            UPD_FILL, UPD_EVICT: begin
                st_d.valid[new_slot] = 1'b1;
                st_d.tag[new_slot]   = up_key;
                st_d.tgt[new_slot]   = up_tgt_word;
                if (kind_d == UPD_EVICT) begin
                    st_d.rr = (st_q.rr == LAST) ? '0 : st_q.rr + 1'b1;
                end
            end
            UPD_DROP: begin
                st_d.valid[up_idx] = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6: dropping a present branch removes exactly one entry
    p_drop_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && up_found)
        |=> ($countones(st_q.valid) + 1 == $countones($past(st_q.valid))));

    // R6: a not-taken branch that is absent changes no validity
    p_drop_absent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_taken && !up_found) |=> $stable(st_q.valid));

    // R7: a new branch with free room grows the table by one
    p_fill_grow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !up_found && !(&st_q.valid))
        |=> ($countones(st_q.valid) == $countones($past(st_q.valid)) + 1));

    // R5: retargeting a present branch leaves validity unchanged
    p_retarget_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && up_found) |=> $stable(st_q.valid));

    // R8: a full table stays full and the pointer moves on by one
    p_evict_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_taken && !up_found && (&st_q.valid))
        |=> ((&st_q.valid) &&
             (st_q.rr == (($past(st_q.rr) == LAST) ? '0 : $past(st_q.rr) + 1'b1))));

    // R9: no valid update means no change to the table
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> ($stable(st_q.valid) && $stable(st_q.tag) &&
                       $stable(st_q.tgt) && $stable(st_q.rr)));

    // R4: a hit always yields a word-aligned next address
    p_aligned_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_next_pc[ALIGN-1:0] == '0));

endmodule

// File: tb/brtgt_buffer_bench.sv
`timescale 1ns/1ps
module brtgt_buffer_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] lk_pc;
    logic        lk_hit;
    logic [31:0] lk_next_pc;
    logic        up_valid;
    logic [31:0] up_pc;
    logic [31:0] up_target;
    logic        up_taken;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    brtgt_buffer u_brtgt_buffer (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_pc      (lk_pc),
        .lk_hit     (lk_hit),
        .lk_next_pc (lk_next_pc),
        .up_valid   (up_valid),
        .up_pc      (up_pc),
        .up_target  (up_target),
        .up_taken   (up_taken)
    );

    typedef struct packed {
        logic        uv;
        logic        ut;
        logic [31:0] upc;
        logic [31:0] utgt;
        logic [31:0] lpc;
        logic        ehit;
        logic [31:0] enext;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VT [NV] = '{
        '{1'b0, 1'b0, 32'h0,   32'h0,    32'h100,      1'b0, 32'h104},   // R1
        '{1'b1, 1'b1, 32'h100, 32'h2000, 32'h100,      1'b0, 32'h104},   // R10
        '{1'b0, 1'b0, 32'h0,   32'h0,    32'h100,      1'b1, 32'h2000},  // R3
        '{1'b1, 1'b1, 32'h200, 32'h3003, 32'h102,      1'b1, 32'h2000},  // R4
        '{1'b0, 1'b0, 32'h0,   32'h0,    32'h200,      1'b1, 32'h3000},  // R4
        '{1'b1, 1'b1, 32'h100, 32'h4000, 32'h100,      1'b1, 32'h2000},  // R10
        '{1'b0, 1'b0, 32'h0,   32'h0,    32'h100,      1'b1, 32'h4000},  // R5
        '{1'b1, 1'b0, 32'h200, 32'h0,    32'h200,      1'b1, 32'h3000},  // R10
        '{1'b0, 1'b0, 32'h0,   32'h0,    32'h200,      1'b0, 32'h204},   // R6
        '{1'b1, 1'b0, 32'h500, 32'h0,    32'h100,      1'b1, 32'h4000},  // R6
        '{1'b0, 1'b1, 32'h600, 32'h7000, 32'h600,      1'b0, 32'h604},   // R9
        '{1'b0, 1'b0, 32'h0,   32'h0,    32'h600,      1'b0, 32'h604},   // R9
        '{1'b0, 1'b0, 32'h0,   32'h0,    32'hFFFFFFFC, 1'b0, 32'h0}      // R2
    };

    function automatic string vreq(int i);
        case (i)
            0:        return "R1";
            1, 5, 7:  return "R10";
            2:        return "R3";
            3, 4:     return "R4";
            6:        return "R5";
            8, 9:     return "R6";
            10, 11:   return "R9";
            default:  return "R2";
        endcase
    endfunction

    task automatic chk(string rq, logic eh, logic [31:0] en);
        n_vec++;
        if (lk_hit !== eh || lk_next_pc !== en) begin
            n_bad++;
            $display("FAIL %s pc=%h: hit=%0b next=%h expected hit=%0b next=%h",
                     rq, lk_pc, lk_hit, lk_next_pc, eh, en);
        end
    endtask

    task automatic upd(logic [31:0] pc, logic [31:0] tg, logic tk);
        @(negedge clk);
        up_valid = 1'b1; up_pc = pc; up_target = tg; up_taken = tk;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic look(string rq, logic [31:0] pc, logic eh, logic [31:0] en);
        @(negedge clk);
        lk_pc = pc;
        #1 chk(rq, eh, en);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] fpc(int i);
        return 32'h0001_0000 + 32'(i) * 8;
    endfunction

    function automatic logic [31:0] ftg(int i);
        return 32'h0009_0000 + 32'(i) * 16;
    endfunction

    localparam logic [31:0] NEW0 = 32'h000D_0000;
    localparam logic [31:0] ZPC  = 32'h0002_0000, ZTG = 32'h000A_0000;
    localparam logic [31:0] XPC  = 32'h0003_0000, XTG = 32'h000B_0000;
    localparam logic [31:0] YPC  = 32'h0004_0000, YTG = 32'h000C_0000;

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; lk_pc = '0; up_valid = 1'b0;
        up_pc = '0; up_target = '0; up_taken = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // Vector walk: update and lookup share each cycle.
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            up_valid = VT[i].uv; up_taken = VT[i].ut;
            up_pc = VT[i].upc; up_target = VT[i].utgt;
            lk_pc = VT[i].lpc;
            #1 chk(vreq(i), VT[i].ehit, VT[i].enext);
        end
        @(negedge clk);
        up_valid = 1'b0;

        // R1: a second reset clears a populated table
        do_reset();
        look("R1", 32'h100, 1'b0, 32'h104);

        // R5 and R7: fill in order, retarget entry 0 midway
        for (int i = 0; i < 15; i++) upd(fpc(i), ftg(i), 1'b1);
        upd(fpc(0), NEW0, 1'b1);
        upd(fpc(15), ftg(15), 1'b1);
        look("R5", fpc(0), 1'b1, NEW0);
        for (int i = 1; i < 16; i++) look("R7", fpc(i), 1'b1, ftg(i));

        // R7: a freed slot is reused before any eviction
        upd(fpc(5), 32'h0, 1'b0);
        look("R6", fpc(5), 1'b0, fpc(5) + 4);
        upd(ZPC, ZTG, 1'b1);
        look("R7", ZPC, 1'b1, ZTG);
        look("R7", fpc(0), 1'b1, NEW0);
        look("R7", fpc(15), 1'b1, ftg(15));

        // R8: full table, rotating replacement from entry 0
        upd(XPC, XTG, 1'b1);
        look("R8", fpc(0), 1'b0, fpc(0) + 4);
        look("R8", XPC, 1'b1, XTG);
        look("R8", fpc(1), 1'b1, ftg(1));
        upd(YPC, YTG, 1'b1);
        look("R8", fpc(1), 1'b0, fpc(1) + 4);
        look("R8", YPC, 1'b1, YTG);
        look("R8", fpc(2), 1'b1, ftg(2));
        look("R8", ZPC, 1'b1, ZTG);
        look("R8", XPC, 1'b1, XTG);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule